// File: doc/BRIEF.md
# Mixed-Sign Registered Multiplier Core

This block multiplies two 16-bit operands and returns a 32-bit product. Each operand sits in its own input register together with a mode bit. The mode bit says whether the operand is read as two's complement or as unsigned magnitude. Because each operand carries its own mode bit, signed×signed, unsigned×unsigned and mixed-sign products all come from the same datapath.

Each operand register has its own active-low load enable. A round request is registered whenever either enable is asserted. When the registered round bit is set, the block adds a half-unit at the boundary of the upper result half. Dropping the low 16 bits of the product then gives a rounded 16-bit result.

The product is combinational after the input registers. It reflects newly loaded operands in the cycle that follows the loading edge. Output formatting, result registers and output muxing are left to the surrounding logic.

Top module: `mixsign_mul_core`

## Requirements
- R1: On a rising clock edge with `a_load_n` low, the A register captures `a_data` and `a_mode` together. With `a_load_n` high, both keep their values.
- R2: On a rising clock edge with `b_load_n` low, the B register captures `b_data` and `b_mode` together. With `b_load_n` high, both keep their values.
- R3: A mode bit of 1 reads its operand as two's complement and 0 reads it as unsigned. Each operand's mode is independent of the other. With the round bit clear, `product` equals the exact product of the two values read this way, taken modulo 2^32.
- R4: The round bit is captured from `rnd_req` on a rising edge when `a_load_n` or `b_load_n` is low. When both enables are high, the round bit keeps its value.
- R5: When the registered round bit is 1, `product` is the R3 result plus 2^15 (a 1 added at bit 15). The sum wraps modulo 2^32 and no flag is raised.
- R6: Asserting `rst_n` low clears both operands, both mode bits and the round bit at once, so `product` reads 0.
- R7: `product` shows the newly registered operands and round bit before the next rising edge. There is no additional pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| a_data | input | 16 | Operand A value |
| a_mode | input | 1 | Operand A mode: 1 two's complement, 0 unsigned |
| a_load_n | input | 1 | Active-low load enable for operand A |
| b_data | input | 16 | Operand B value |
| b_mode | input | 1 | Operand B mode: 1 two's complement, 0 unsigned |
| b_load_n | input | 1 | Active-low load enable for operand B |
| rnd_req | input | 1 | Round request, captured when either enable is low |
| product | output | 32 | Product of the registered operands, rounding included |

## Verification
Some properties are checked by assertions on every cycle:
- each operand register holds while its enable is high;
- the round bit holds while both enables are high;
- a zero operand gives 0 when the round bit is clear, and exactly 2^15 when it is set;
- the sign of the product is correct for a nonzero unsigned operand times a negative signed operand.

Other behaviour only the bench scenarios can show. These are the exact product values across the four mode combinations and the most negative operands, and the wrap of the round addition past 2^32. They also cover the capture of the round request under one enable only, and the clearing of all state by a mid-run reset.

// File: rtl/mulcore_pkg.sv
package mulcore_pkg;

  // Interpretation of an operand register
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } opmode_e;

endpackage

// File: rtl/mulcore_operand_reg.sv
module mulcore_operand_reg
  import mulcore_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] d_value,
  input  opmode_e      d_mode,
  output logic [W-1:0] q_value,
  output opmode_e      q_mode
);

  logic [W-1:0] value_nx;
  opmode_e      mode_nx;

  always_comb begin
    value_nx = q_value;
    mode_nx  = q_mode;
    if (!load_n) begin
      value_nx = d_value;
      mode_nx  = d_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_value <= '0;
      q_mode  <= MODE_UNSIGNED;
    end else begin
      q_value <= value_nx;
      q_mode  <= mode_nx;
    end
  end

  // R1/R2: a blocked register keeps value and mode
  p_hold_operand_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> ($stable(q_value) && $stable(q_mode)));

endmodule

// File: rtl/mulcore_round_reg.sv
module mulcore_round_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic a_load_n,
  input  logic b_load_n,
  input  logic rnd_req,
  output logic rnd_q
);

  logic capture;
  logic rnd_nx;

  always_comb begin
    capture = !a_load_n || !b_load_n;
    rnd_nx  = capture ? rnd_req : rnd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd_q <= 1'b0;
    else        rnd_q <= rnd_nx;
  end

  p_hold_round_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_load_n && b_load_n) |=> $stable(rnd_q));

endmodule

// File: rtl/mulcore_mixed_mult.sv
module mulcore_mixed_mult
  import mulcore_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_value,
  input  opmode_e        a_mode,
  input  logic [W-1:0]   b_value,
  input  opmode_e        b_mode,
  input  logic           rnd,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic signed [W:0] a_ext;
  logic signed [W:0] b_ext;
  logic [PW-1:0]     prod_raw;
  logic [PW-1:0]     rnd_term;

  always_comb begin
    // fill the extra top bit with the sign only for two's complement operands
    a_ext    = {(a_mode == MODE_SIGNED) & a_value[W-1], a_value};
    b_ext    = {(b_mode == MODE_SIGNED) & b_value[W-1], b_value};
    prod_raw = PW'(a_ext * b_ext);
    rnd_term = {{(W+1){1'b0}}, rnd, {(W-1){1'b0}}};
    product  = prod_raw + rnd_term;
  end

endmodule

// File: rtl/mixsign_mul_core.sv
module mixsign_mul_core
  import mulcore_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a_data,
  input  logic           a_mode,
  input  logic           a_load_n,
  input  logic [W-1:0]   b_data,
  input  logic           b_mode,
  input  logic           b_load_n,
  input  logic           rnd_req,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  opmode_e      a_mode_q;
  opmode_e      b_mode_q;
  logic         rnd_q;

  mulcore_operand_reg #(.W(W)) u_a_reg (
    .clk(clk), .rst_n(rst_n), .load_n(a_load_n),
    .d_value(a_data), .d_mode(opmode_e'(a_mode)),
    .q_value(a_q), .q_mode(a_mode_q)
  );

  mulcore_operand_reg #(.W(W)) u_b_reg (
    .clk(clk), .rst_n(rst_n), .load_n(b_load_n),
    .d_value(b_data), .d_mode(opmode_e'(b_mode)),
    .q_value(b_q), .q_mode(b_mode_q)
  );

  mulcore_round_reg u_rnd_reg (
    .clk(clk), .rst_n(rst_n), .a_load_n(a_load_n), .b_load_n(b_load_n),
    .rnd_req(rnd_req), .rnd_q(rnd_q)
  );

  mulcore_mixed_mult #(.W(W)) u_mult (
    .a_value(a_q), .a_mode(a_mode_q),
    .b_value(b_q), .b_mode(b_mode_q),
    .rnd(rnd_q), .product(product)
  );

  // R3: a zero operand with no rounding gives zero
  p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_q == '0 || b_q == '0) && !rnd_q) |-> (product == '0));

  // R5: a zero operand with rounding leaves only the half-unit
  p_round_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_q == '0 || b_q == '0) && rnd_q) |-> (product == PW'(1) << (W-1)));

  // R3: nonzero unsigned A times negative signed B is negative
  p_mixed_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mode_q == MODE_UNSIGNED && a_q != '0 && b_mode_q == MODE_SIGNED &&
     b_q[W-1] && !rnd_q) |-> product[PW-1]);

endmodule

// File: tb/mixsign_mul_core_tb.sv
`timescale 1ns/1ps
module mixsign_mul_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a_data = '0;
  logic        a_mode = 1'b0;
  logic        a_load_n = 1'b1;
  logic [15:0] b_data = '0;
  logic        b_mode = 1'b0;
  logic        b_load_n = 1'b1;
  logic        rnd_req = 1'b0;
  logic [31:0] product;

  int checks = 0;
  int failures = 0;
  string cur_req = "R6";

  // behavioural model state
  longint m_a = 0, m_b = 0;
  bit     m_as = 0, m_bs = 0, m_rnd = 0;

  always #2 clk = ~clk;

  mixsign_mul_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_data(a_data), .a_mode(a_mode), .a_load_n(a_load_n),
    .b_data(b_data), .b_mode(b_mode), .b_load_n(b_load_n),
    .rnd_req(rnd_req), .product(product)
  );

  function automatic logic [31:0] expect_val();
    longint va, vb, p;
    va = (m_as && m_a >= 32768) ? m_a - 65536 : m_a;
    vb = (m_bs && m_b >= 32768) ? m_b - 65536 : m_b;
    p  = va * vb + (m_rnd ? 32768 : 0);
    return p[31:0];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s product=%h expected=%h", req, got, exp);
    end
  endtask

  always @(negedge rst_n) begin
    m_a = 0; m_b = 0; m_as = 0; m_bs = 0; m_rnd = 0;
  end

  // R7: model updates at the edge, product compared 1 ns later
  always @(posedge clk) begin
    if (rst_n) begin
      if (!a_load_n) begin m_a = a_data; m_as = a_mode; end
      if (!b_load_n) begin m_b = b_data; m_bs = b_mode; end
      if (!a_load_n || !b_load_n) m_rnd = rnd_req;
      #1;
      check(cur_req, product, expect_val());
    end
  end

  task automatic drive(string req, logic [15:0] a, logic as, logic la,
                       logic [15:0] b, logic bs, logic lb, logic r);
    @(negedge clk);
    cur_req = req;
    a_data = a; a_mode = as; a_load_n = la;
    b_data = b; b_mode = bs; b_load_n = lb; rnd_req = r;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #9;
    check("R6", product, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    drive("R3", 16'd3, 1, 0, 16'd5, 0, 0, 0);          // 15
    drive("R3", 16'hFFFE, 1, 0, 16'd7, 1, 0, 0);       // -14
    drive("R3", 16'hFFFF, 0, 0, 16'hFFFF, 1, 0, 0);    // 65535 * -1
    drive("R3", 16'hFFFF, 0, 0, 16'hFFFF, 0, 0, 0);    // 0xFFFE0001
    drive("R3", 16'h8000, 1, 0, 16'h8000, 1, 0, 0);    // 2^30
    drive("R3", 16'h8000, 1, 0, 16'hFFFF, 0, 0, 0);    // mixed most negative
    drive("R1", 16'd1234, 0, 1, 16'd2, 0, 0, 0);       // A held
    drive("R1", 16'd999, 1, 1, 16'd3, 1, 0, 0);
    drive("R2", 16'd6, 0, 0, 16'd77, 1, 1, 0);         // B held
    drive("R2", 16'd7, 1, 0, 16'h8000, 0, 1, 0);
    drive("R5", 16'd1, 0, 0, 16'd1, 0, 0, 1);          // 1 + 2^15
    drive("R4", 16'd2, 0, 0, 16'd1, 0, 1, 0);          // round cleared via A enable only
    drive("R4", 16'd2, 0, 1, 16'd1, 0, 0, 1);          // round set via B enable only
    drive("R4", 16'd5, 0, 1, 16'd5, 0, 1, 0);          // both blocked: round held at 1
    drive("R4", 16'd5, 0, 1, 16'd5, 0, 1, 0);
    drive("R5", 16'hFFFF, 1, 0, 16'd1, 0, 0, 1);       // -1 + 2^15 wraps to 0x7FFF
    drive("R5", 16'h8000, 1, 0, 16'd1, 0, 0, 1);       // -32768 + 32768 = 0
    drive("R5", 16'd0, 0, 0, 16'd9, 0, 0, 1);          // round only
    drive("R7", 16'd100, 0, 0, 16'd200, 0, 0, 0);
    drive("R7", 16'd101, 0, 0, 16'd201, 0, 1, 0);
    drive("R7", 16'd101, 0, 1, 16'd201, 0, 1, 0);
    @(negedge clk);
    #1; rst_n = 1'b0;
    #1; check("R6", product, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    drive("R6", 16'd4, 0, 1, 16'd4, 0, 1, 1);          // nothing loads after reset
    drive("R6", 16'd4, 0, 1, 16'd4, 0, 1, 1);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule